// File: doc/BRIEF.md
# AC-link Two-Channel PCM Transmitter

This block serializes PCM audio from two independent channels, A and B, onto the output half of an AC'97-style serial link. A host writes configuration and samples through a simple synchronous write port. Each channel has a holding register for the next sample and a per-channel mode that selects enable, sample width and byte order. At the start of every frame the holding register moves into a slot sample register, and the channel's ready flag goes high to ask for the next sample.

A frame lasts 256 bit clocks. It begins with a 16-bit tag slot, with the frame sync high, and then carries twelve 20-bit data slots. A host-programmed slot map routes channel A, channel B or nothing to each of slots 3 through 12. A channel may feed several slots, and it then repeats the same sample in each of them. Every sample is left-justified in its 20-bit slot and sent most significant bit first. The tag marks which slots carry fresh data. If an enabled channel has no sample ready when a frame starts, its slots go out as zeros with their valid bits clear, and a sticky underrun flag records the event.

The whole block runs on the bit clock. Frame sync and serial data change just after its rising edge.

Top module: `aclink_pcm_tx`

## Requirements
- R1: While the global enable (address 0, bit 0) is clear, `sync` and `sdata` stay low. After the write that sets it, `sync` is low in the following cycle and high in the cycle after that, which is the first bit of the first frame.
- R2: A frame is 256 cycles long. `sync` is high for exactly its first 16 cycles and low for the other 240, and frames follow each other without a gap.
- R3: The tag slot is sent in frame cycles 0 to 15. Cycle 0 carries the frame-valid bit, which is the OR of all slot valid bits. Cycle k, for k from 1 to 12, carries the valid bit of slot k. Cycles 13 to 15 are zero.
- R4: The slot map (address 3) gives slot s, for s from 3 to 12, a 2-bit code at bits [2(s-3)+1 : 2(s-3)]: 0 means none, 1 means channel A, 2 means channel B, and 3 means none. Slots 1, 2 and unmapped slots are sent as zeros with their valid bits clear. The map is captured at the start of each frame.
- R5: Mode bits [2:1] select the sample width: 0 is 10 bits, 1 is 16, 2 is 18 and 3 is 20. The sample is taken from the low bits of the word, left-justified in the 20-bit slot, and zero-padded below.
- R6: With mode bit 3 set (byte-swapped order), a 16-bit sample uses the word with bytes 0 and 1 exchanged. An 18- or 20-bit sample uses the low three bytes in reverse order. A 10-bit sample is not affected.
- R7: Slot s occupies frame cycles 16+20(s-1) to 35+20(s-1), and its bits are sent most significant bit first.
- R8: A channel's `txrdy` is high after reset and after its holding register is moved out at a frame start. It is low in the cycle after a write to that channel's holding register (address 4 for A, 5 for B).
- R9: `tx_irq` of a channel equals its `txrdy` ANDed with the channel enable (mode bit 0) and the global enable.
- R10: If an enabled channel's holding register is empty at a frame start, its slots carry zeros with their valid bits clear in that frame, and its `underrun` bit is set. The bit stays set until a write to address 6 with that channel's bit set (bit 0 for A, bit 1 for B).
- R11: A channel with mode bit 0 clear never marks a slot valid, sends zeros in its slots and never sets its underrun bit.
- R12: Mode registers are at address 1 for channel A and 2 for channel B. A holding write made in the cycle where a frame starts is kept for the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host register address |
| wr_data | input | 24 | Host write data |
| sync | output | 1 | Frame sync, high during the tag slot |
| sdata | output | 1 | Serial slot data, most significant bit first |
| txrdy | output | 2 | Per-channel holding register empty (bit 0 is A) |
| tx_irq | output | 2 | Per-channel level interrupt request |
| underrun | output | 2 | Per-channel sticky underrun flag |

## Verification
Any error in the slot or bit counters moves either the sync pulse or some data bit within the first 256-cycle frame, so each frame is captured whole and compared bit by bit against a frame built from the model. A wrong width or byte-order decode, or a wrong slot-map decode, corrupts the matching slot bits in the first frame that carries the channel. A holding register that is not emptied, or a full flag that is stale, shows either as `txrdy` staying low one frame later or as a missing or unexpected underrun. Random modes, maps and skipped writes are combined with directed frames for underrun, a disabled channel and a reserved map code.

// File: rtl/aclink_pkg.sv
package aclink_pkg;

    localparam int HOST_W  = 24;
    localparam int ADDR_W  = 3;
    localparam int SLOT_W  = 20;
    localparam int TAG_W   = 16;
    localparam int N_SLOT  = 12;
    localparam int MAP_LO  = 3;
    localparam int N_MAP   = N_SLOT - MAP_LO + 1;
    localparam int MAP_W   = 2 * N_MAP;
    localparam int N_CH    = 2;
    localparam int FRAME_W = TAG_W + N_SLOT * SLOT_W;

    localparam int A_CTRL  = 0;
    localparam int A_MODE0 = 1;
    localparam int A_MAP   = 3;
    localparam int A_HOLD0 = 4;
    localparam int A_UCLR  = 6;

    typedef enum logic [1:0] {SZ_10 = 2'd0, SZ_16 = 2'd1, SZ_18 = 2'd2, SZ_20 = 2'd3} smp_size_e;
    typedef enum logic [1:0] {SRC_NONE = 2'd0, SRC_A = 2'd1, SRC_B = 2'd2, SRC_RSV = 2'd3} slot_src_e;

    typedef struct packed {
        logic      swap;
        smp_size_e size;
        logic      en;
    } chan_mode_t;

    function automatic logic [SLOT_W-1:0] fmt_sample(input logic [HOST_W-1:0] w,
                                                     input chan_mode_t m);
        logic [HOST_W-1:0] x;
        logic [SLOT_W-1:0] r;
        x = w;
        if (m.swap && m.size == SZ_16)
            x[15:0] = {w[7:0], w[15:8]};
        else if (m.swap && (m.size == SZ_18 || m.size == SZ_20))
            x = {w[7:0], w[15:8], w[23:16]};
        case (m.size)
            SZ_10:   r = {x[9:0], 10'd0};
            SZ_16:   r = {x[15:0], 4'd0};
            SZ_18:   r = {x[17:0], 2'd0};
            default: r = x[19:0];
        endcase
        return r;
    endfunction

endpackage

// File: rtl/aclink_regs.sv
module aclink_regs
    import aclink_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [MAP_W-1:0]        wr_low,
    output logic                    glb_en,
    output chan_mode_t [N_CH-1:0]   mode,
    output logic [MAP_W-1:0]        slot_map,
    output logic [N_CH-1:0]         hold_wr,
    output logic [N_CH-1:0]         urun_clr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            glb_en   <= 1'b0;
            mode     <= '0;
            slot_map <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(A_CTRL))
                glb_en <= wr_low[0];
            if (wr_addr == ADDR_W'(A_MAP))
                slot_map <= wr_low;
            for (int ch = 0; ch < N_CH; ch++) begin
                if (wr_addr == ADDR_W'(A_MODE0 + ch))
                    mode[ch] <= chan_mode_t'(wr_low[3:0]);
            end
        end
    end

    always_comb begin
        for (int ch = 0; ch < N_CH; ch++) begin
            hold_wr[ch]  = wr_en && (wr_addr == ADDR_W'(A_HOLD0 + ch));
            urun_clr[ch] = wr_en && (wr_addr == ADDR_W'(A_UCLR)) && wr_low[ch];
        end
    end

endmodule

// File: rtl/aclink_chan.sv
module aclink_chan
    import aclink_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                glb_en,
    input  chan_mode_t          mode,
    input  logic                hold_wr,
    input  logic [HOST_W-1:0]   wr_data,
    input  logic                load,
    input  logic                urun_clr,
    output logic                txrdy,
    output logic                irq,
    output logic [SLOT_W-1:0]   smp,
    output logic                smp_vld,
    output logic                urun
);

    logic [HOST_W-1:0] hold_q;
    logic              full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            full_q  <= 1'b0;
            smp     <= '0;
            smp_vld <= 1'b0;
            urun    <= 1'b0;
        end else begin
            if (hold_wr)
                hold_q <= wr_data;
            full_q <= hold_wr | (full_q & ~load);
            if (load) begin
                smp_vld <= mode.en & full_q;
                smp     <= (mode.en && full_q) ? fmt_sample(hold_q, mode) : '0;
            end
            if (load && mode.en && !full_q)
                urun <= 1'b1;
            else if (urun_clr)
                urun <= 1'b0;
        end
    end

    assign txrdy = ~full_q;
    assign irq   = txrdy & mode.en & glb_en;

endmodule

// File: rtl/aclink_framer.sv
module aclink_framer
    import aclink_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         glb_en,
    input  logic [MAP_W-1:0]             slot_map,
    input  logic [N_CH-1:0][SLOT_W-1:0]  smp,
    input  logic [N_CH-1:0]              smp_vld,
    output logic                         load,
    output logic                         sync,
    output logic                         sdata
);

    localparam int SI_W = $clog2(N_SLOT + 1);
    localparam int BI_W = $clog2(SLOT_W);

    logic             active;
    logic [SI_W-1:0]  slot_q;
    logic [BI_W-1:0]  bit_q;
    logic [MAP_W-1:0] map_q;
    logic             last_bit;
    logic [N_SLOT:0]  slot_v;
    logic [TAG_W-1:0] tag;
    slot_src_e        cur_src;

    assign last_bit = active && slot_q == SI_W'(N_SLOT) && bit_q == BI_W'(SLOT_W - 1);
    assign load     = glb_en && (!active || last_bit);

    always_ff @(posedge clk) begin
        if (rst || !glb_en) begin
            active <= 1'b0;
            slot_q <= '0;
            bit_q  <= '0;
            if (rst)
                map_q <= '0;
        end else if (load) begin
            active <= 1'b1;
            slot_q <= '0;
            bit_q  <= '0;
            map_q  <= slot_map;
        end else if (slot_q == '0 && bit_q == BI_W'(TAG_W - 1)) begin
            slot_q <= SI_W'(1);
            bit_q  <= '0;
        end else if (slot_q != '0 && bit_q == BI_W'(SLOT_W - 1)) begin
            slot_q <= slot_q + SI_W'(1);
            bit_q  <= '0;
        end else begin
            bit_q <= bit_q + BI_W'(1);
        end
    end

    always_comb begin
        slot_v  = '0;
        cur_src = SRC_NONE;
        for (int s = MAP_LO; s <= N_SLOT; s++) begin
            slot_src_e src;
            src       = slot_src_e'(map_q[2*(s-MAP_LO) +: 2]);
            slot_v[s] = (src == SRC_A && smp_vld[0]) || (src == SRC_B && smp_vld[1]);
            if (slot_q == SI_W'(s))
                cur_src = src;
        end
    end

    always_comb begin
        tag = '0;
        tag[TAG_W-1] = |slot_v;
        for (int s = 1; s <= N_SLOT; s++)
            tag[TAG_W-1-s] = slot_v[s];
    end

    always_comb begin
        sdata = 1'b0;
        if (active) begin
            if (slot_q == '0)
                sdata = tag[4'(TAG_W - 1) - bit_q[3:0]];
            else if (cur_src == SRC_A && smp_vld[0])
                sdata = smp[0][BI_W'(SLOT_W - 1) - bit_q];
            else if (cur_src == SRC_B && smp_vld[1])
                sdata = smp[1][BI_W'(SLOT_W - 1) - bit_q];
        end
    end

    assign sync = active && slot_q == '0;

endmodule

// File: rtl/aclink_pcm_tx.sv
module aclink_pcm_tx
    import aclink_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [HOST_W-1:0]   wr_data,
    output logic                sync,
    output logic                sdata,
    output logic [N_CH-1:0]     txrdy,
    output logic [N_CH-1:0]     tx_irq,
    output logic [N_CH-1:0]     underrun
);

    logic                        glb_en;
    chan_mode_t [N_CH-1:0]       mode;
    logic [MAP_W-1:0]            slot_map;
    logic [N_CH-1:0]             hold_wr;
    logic [N_CH-1:0]             urun_clr;
    logic                        load;
    logic [N_CH-1:0][SLOT_W-1:0] smp;
    logic [N_CH-1:0]             smp_vld;

    aclink_regs i_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_low   (wr_data[MAP_W-1:0]),
        .glb_en   (glb_en),
        .mode     (mode),
        .slot_map (slot_map),
        .hold_wr  (hold_wr),
        .urun_clr (urun_clr)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        aclink_chan i_chan (
            .clk      (clk),
            .rst      (rst),
            .glb_en   (glb_en),
            .mode     (mode[ch]),
            .hold_wr  (hold_wr[ch]),
            .wr_data  (wr_data),
            .load     (load),
            .urun_clr (urun_clr[ch]),
            .txrdy    (txrdy[ch]),
            .irq      (tx_irq[ch]),
            .smp      (smp[ch]),
            .smp_vld  (smp_vld[ch]),
            .urun     (underrun[ch])
        );
    end

    aclink_framer i_framer (
        .clk      (clk),
        .rst      (rst),
        .glb_en   (glb_en),
        .slot_map (slot_map),
        .smp      (smp),
        .smp_vld  (smp_vld),
        .load     (load),
        .sync     (sync),
        .sdata    (sdata)
    );

endmodule

// File: rtl/aclink_pcm_tx_chk.sv
module aclink_pcm_tx_chk
    import aclink_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic [N_CH-1:0]     clr_bits,
    input logic                sync,
    input logic [N_CH-1:0]     txrdy,
    input logic [N_CH-1:0]     tx_irq,
    input logic [N_CH-1:0]     underrun
);

    logic [4:0] sync_run;

    always_ff @(posedge clk) begin
        if (rst)
            sync_run <= '0;
        else if (sync)
            sync_run <= (sync_run == 5'd31) ? sync_run : sync_run + 5'd1;
        else
            sync_run <= '0;
    end

    // R2
    sync_len_chk: assert property (@(posedge clk) disable iff (rst)
        sync |-> sync_run < 5'd16);

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chk
        // R8
        txrdy_drop_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_addr == ADDR_W'(A_HOLD0 + ch)) |=> !txrdy[ch]);

        // R9
        irq_needs_rdy_chk: assert property (@(posedge clk) disable iff (rst)
            tx_irq[ch] |-> txrdy[ch]);

        // R10
        urun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            (underrun[ch] && !(wr_en && wr_addr == ADDR_W'(A_UCLR) && clr_bits[ch]))
            |=> underrun[ch]);
    end

endmodule

bind aclink_pcm_tx aclink_pcm_tx_chk i_pcm_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .clr_bits (wr_data[1:0]),
    .sync     (sync),
    .txrdy    (txrdy),
    .tx_irq   (tx_irq),
    .underrun (underrun)
);

// File: tb/test_aclink_pcm_tx.sv
`timescale 1ns/1ps
module test_aclink_pcm_tx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [23:0] wr_data = '0;
    logic        sync, sdata;
    logic [1:0]  txrdy, tx_irq, underrun;

    aclink_pcm_tx i_aclink_pcm_tx (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sync(sync), .sdata(sdata), .txrdy(txrdy), .tx_irq(tx_irq), .underrun(underrun)
    );

    always #2 clk = ~clk;

    int total = 0;
    int bad   = 0;

    // model state
    logic        m_en   [2];
    logic [1:0]  m_size [2];
    logic        m_swap [2];
    logic [19:0] m_map;
    logic        m_full [2];
    logic [23:0] m_hold [2];
    logic        m_urun [2];
    // state latched at frame start
    logic        f_vld  [2];
    logic [19:0] f_smp  [2];
    logic [19:0] f_map;
    // per-frame write plan
    logic [2:0]  pw_addr [8];
    logic [23:0] pw_data [8];
    int          pw_n;
    logic [255:0] cap_d, cap_s, exp_d;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [19:0] b_fmt(input logic [23:0] w, input logic [1:0] sz, input logic sw);
        logic [23:0] v;
        v = sw ? {w[7:0], w[15:8], w[23:16]} : w;
        case (sz)
            2'd0:    return {w[9:0], 10'h0};
            2'd1:    return sw ? {w[7:0], w[15:8], 4'h0} : {w[15:0], 4'h0};
            2'd2:    return {v[17:0], 2'b00};
            default: return v[19:0];
        endcase
    endfunction

    task automatic apply_model(input logic [2:0] a, input logic [23:0] d);
        case (a)
            3'd1, 3'd2: begin
                m_en[a-1] = d[0]; m_size[a-1] = d[2:1]; m_swap[a-1] = d[3];
            end
            3'd3: m_map = d[19:0];
            3'd4, 3'd5: begin m_hold[a-4] = d; m_full[a-4] = 1'b1; end
            3'd6: begin
                if (d[0]) m_urun[0] = 1'b0;
                if (d[1]) m_urun[1] = 1'b0;
            end
            default: ;
        endcase
    endtask

    task automatic host_wr(input logic [2:0] a, input logic [23:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        apply_model(a, d);
    endtask

    // frame start: model of the holding-to-slot transfer
    task automatic model_load();
        for (int c = 0; c < 2; c++) begin
            f_vld[c] = m_en[c] && m_full[c];
            f_smp[c] = f_vld[c] ? b_fmt(m_hold[c], m_size[c], m_swap[c]) : 20'h0;
            if (m_en[c] && !m_full[c]) m_urun[c] = 1'b1;
            m_full[c] = 1'b0;
        end
        f_map = m_map;
    endtask

    // R3 R4 R7: expected serial frame
    function automatic logic [255:0] build_frame();
        logic [255:0] e;
        logic [12:0]  sv;
        logic [1:0]   code;
        e  = '0;
        sv = '0;
        for (int s = 3; s <= 12; s++) begin
            code  = f_map[2*(s-3) +: 2];
            sv[s] = (code == 2'd1 && f_vld[0]) || (code == 2'd2 && f_vld[1]);
        end
        e[0] = |sv;
        for (int k = 1; k <= 12; k++) e[k] = sv[k];
        for (int s = 3; s <= 12; s++) begin
            code = f_map[2*(s-3) +: 2];
            for (int b = 0; b < 20; b++) begin
                if (sv[s])
                    e[16 + (s-1)*20 + b] = (code == 2'd1) ? f_smp[0][19-b] : f_smp[1][19-b];
            end
        end
        return e;
    endfunction

    task automatic add_plan(input logic [2:0] a, input logic [23:0] d);
        pw_addr[pw_n] = a; pw_data[pw_n] = d; pw_n++;
    endtask

    task automatic make_plan(input int f);
        pw_n = 0;
        if (f == 0) begin
            add_plan(3'd1, 24'h000001);       // A: 10-bit, enabled
            add_plan(3'd2, 24'h00000D);       // B: 18-bit, swapped
            add_plan(3'd4, 24'h0002A5);
            add_plan(3'd5, 24'h123456);
        end else if (f == 1) begin
            // no samples: both channels underrun next frame (R10)
        end else if (f == 2) begin
            add_plan(3'd6, 24'h000003);       // clear both underruns
            add_plan(3'd2, 24'h000000);       // B disabled (R11)
            add_plan(3'd4, 24'h00BEEF);
        end else begin
            for (int c = 0; c < 2; c++)
                if ($urandom % 4 != 0)
                    add_plan(3'(1 + c), {20'h0, 1'($urandom), 2'($urandom), 1'($urandom % 5 != 0)});
            if ($urandom % 2 == 0) add_plan(3'd3, 24'($urandom));
            for (int c = 0; c < 2; c++)
                if ($urandom % 4 != 0) add_plan(3'(4 + c), 24'($urandom));
            if ($urandom % 4 == 0) add_plan(3'd6, 24'h000003);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [1:0] hw;
        int first;
        void'($urandom(32'd2024));
        for (int c = 0; c < 2; c++) begin
            m_en[c] = 0; m_size[c] = 0; m_swap[c] = 0;
            m_full[c] = 0; m_hold[c] = 0; m_urun[c] = 0;
        end
        m_map = '0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state: R1 R8 R9 R10
        chk(sync == 0 && sdata == 0, "R1", "idle outputs after reset", {sync, sdata}, 0);
        chk(txrdy == 2'b11, "R8", "txrdy after reset", txrdy, 2'b11);
        chk(tx_irq == 2'b00, "R9", "irq after reset", tx_irq, 0);
        chk(underrun == 2'b00, "R10", "underrun after reset", underrun, 0);

        // R12 R6 R4 directed setup: A 16-bit swapped, B 20-bit, reserved code on slot 12
        host_wr(3'd1, 24'h00000B);
        host_wr(3'd2, 24'h000007);
        host_wr(3'd3, 24'h0C0109);
        host_wr(3'd4, 24'h001234);
        host_wr(3'd5, 24'h0ABCDE);
        chk(txrdy == 2'b00, "R8", "txrdy after holding writes", txrdy, 0);
        repeat (5) @(negedge clk);
        chk(sync == 0 && sdata == 0, "R1", "no frame while disabled", {sync, sdata}, 0);

        // R1: enable and check the sync start cycle
        host_wr(3'd0, 24'h000001);
        chk(sync == 0, "R1", "sync one cycle after enable write", sync, 0);
        @(negedge clk);
        chk(sync == 1, "R1", "sync two cycles after enable write", sync, 1);

        for (int f = 0; f < 14; f++) begin
            model_load();
            exp_d = build_frame();
            chk(txrdy == 2'b11, "R8", $sformatf("txrdy at start of frame %0d", f), txrdy, 2'b11);
            chk(tx_irq == {m_en[1], m_en[0]}, "R9", $sformatf("irq at start of frame %0d", f),
                tx_irq, {m_en[1], m_en[0]});
            make_plan(f);
            hw = 2'b00;
            for (int i = 0; i < 256; i++) begin
                cap_d[i] = sdata;
                cap_s[i] = sync;
                if (i >= 100 && i < 100 + pw_n) begin
                    wr_en = 1'b1; wr_addr = pw_addr[i-100]; wr_data = pw_data[i-100];
                    if (pw_addr[i-100] == 3'd4) hw[0] = 1'b1;
                    if (pw_addr[i-100] == 3'd5) hw[1] = 1'b1;
                end else begin
                    wr_en = 1'b0;
                end
                if (i == 100 + pw_n) begin
                    for (int k = 0; k < pw_n; k++) apply_model(pw_addr[k], pw_data[k]);
                    chk((txrdy & hw) == 2'b00, "R8", "txrdy low after holding write", txrdy, ~hw);
                    chk(underrun == {m_urun[1], m_urun[0]}, "R10 R11", "sticky underrun",
                        underrun, {m_urun[1], m_urun[0]});
                end
                @(negedge clk);
            end
            // R2: sync high exactly for the first 16 cycles
            chk(cap_s == {240'h0, 16'hFFFF}, "R2", $sformatf("sync pattern frame %0d", f),
                {31'h0, cap_s[16]}, 0);
            first = -1;
            for (int t = 255; t >= 0; t--) if (cap_d[t] !== exp_d[t]) first = t;
            chk(first < 0, "R3 R4 R5 R6 R7 R10 R11",
                $sformatf("serial frame %0d first bad bit %0d", f, first),
                (first < 0) ? 0 : 32'(cap_d[first]), (first < 0) ? 0 : 32'(exp_d[first]));
        end

        // R1: disable mid-frame, link goes quiet
        repeat (30) @(negedge clk);
        host_wr(3'd0, 24'h000000);
        @(negedge clk);
        for (int i = 0; i < 300; i++) begin
            if (sync || sdata) first = 1;
            @(negedge clk);
        end
        chk(sync == 0 && sdata == 0, "R1", "link quiet after disable", {sync, sdata}, 0);
        chk(tx_irq == 2'b00, "R9", "irq gated by global enable", tx_irq, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule